// File: doc/BRIEF.md
# TLB with hardware table walker

This block translates virtual addresses to physical addresses through a fully associative buffer of recently used page mappings. Each request carries a virtual address, a write flag and an address-space identifier. The upper bits of the address select a page, and the low bits pass through unchanged as the byte offset within the page. Every entry is compared with the page number and the identifier at the same time. When one entry matches, the translated address comes back on the next cycle. Back-to-back hits can be accepted on consecutive cycles.

On a miss the block walks the page table in hardware. It issues one read for the table entry at the table base plus the page number, then checks what comes back. A valid entry is written into the slot that a round-robin pointer selects, and the request then completes. An invalid entry ends the request with a page-fault flag and writes nothing. An access type that the entry's permission bits forbid ends with a protection-fault flag. On either fault the virtual address stays on an output so that a handler can service the fault and restart the access. A flush input drops every entry, or only the entries of one identifier, in a single cycle.

Top module: `pgx_tlb`

## Requirements
- R1: A successful translation returns `rsp_paddr` = {physical page number, `req_vaddr[OFF_W-1:0]`}. The offset bits are not altered.
- R2: A request accepted with `req_ready` high that hits an entry raises `rsp_valid` in the very next cycle and makes no memory read. `req_ready` is high again in that strobe cycle.
- R3: A hit needs a valid entry whose page number and identifier both equal the request's. The same page under a different identifier misses.
- R4: On a miss, `mem_req` rises with `mem_addr` = `tbl_base` + page number. `mem_req` and `mem_addr` hold until `mem_gnt` is seen. Exactly one read is made, and `req_ready` stays low until the walk's response strobe has passed.
- R5: The table entry read as `mem_rdata` has the valid bit at bit 0, read permission at bit 1, write permission at bit 2 and the physical page number at bits [3 +: PA_W-OFF_W]. A valid entry is installed, and its response strobe comes exactly 3 cycles after the cycle in which `mem_rvalid` is seen. A later access to the same page and identifier then hits.
- R6: A fetched entry with bit 0 clear ends the request 2 cycles after `mem_rvalid`, with `rsp_pfault`=1, `rsp_paddr`=0 and no refill, so a repeat access misses again. `fault_vaddr` takes the request's virtual address and holds it until the next fault.
- R7: A read needs bit 1 and a write needs bit 2. A violation gives `rsp_prot_fault`=1, `rsp_paddr`=0 and `fault_vaddr` = the request address. This holds on a hit and at the end of a walk, and a valid entry fetched by the walk is installed even when the access is refused.
- R8: Refills go to the slots in round-robin order, starting at slot 0 after reset and advancing by one per refill. After ENTRIES refills, the next refill replaces the oldest one.
- R9: `flush_valid` with `flush_all`=1 drops every entry. With `flush_all`=0 it drops only the entries whose identifier equals `flush_asid`. Lookups from the next cycle on see the result.
- R10: A lookup in the same cycle as a flush still uses the contents from before the flush. A refill in the same cycle as a flush keeps the newly written entry and drops the others that match.
- R11: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req`=0, `fault_vaddr`=0, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_asid | input | ASID_W | Address-space identifier of the request |
| rsp_valid | output | 1 | One-cycle done strobe |
| rsp_paddr | output | PA_W | Translated address (0 on a fault) |
| rsp_pfault | output | 1 | Page fault, qualified by rsp_valid |
| rsp_prot_fault | output | 1 | Protection fault, qualified by rsp_valid |
| fault_vaddr | output | VA_W | Virtual address of the latest faulting request |
| tbl_base | input | MA_W | Page table base, in table-entry units |
| mem_req | output | 1 | Table read request |
| mem_gnt | input | 1 | Read request accepted |
| mem_addr | output | MA_W | Table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | PA_W-OFF_W+3 | Table entry read data |
| flush_valid | input | 1 | Flush command |
| flush_all | input | 1 | 1 = drop all entries, 0 = by identifier |
| flush_asid | input | ASID_W | Identifier to drop when flush_all is 0 |

## Verification
Two pairs of functions can fall in the same cycle here. A flush can coincide with a hit lookup, and a flush can coincide with the refill write of a walk. The bench provokes the first by raising the flush in the cycle a hit request is accepted. It judges that the response is still a one-cycle hit and that a repeat of the same access then walks. For the second, the memory model counts cycles from its read data and raises a full flush in exactly the refill cycle. The bench then expects the fresh page to hit and the pages loaded earlier to miss. A reference model of the slots, with its own round-robin pointer, predicts hit or miss, latency, address and flags for sweeps across many pages, two identifiers, both access types and two table bases.

// File: rtl/pgx_tlb_pkg.sv
`timescale 1ns/1ps
package pgx_tlb_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_WAIT,
    W_CHECK,
    W_REFILL,
    W_RESPOND
  } walk_st_t;

  // table entry layout: valid, read permission, write permission, page number
  localparam int PTE_V   = 0;
  localparam int PTE_R   = 1;
  localparam int PTE_W   = 2;
  localparam int PTE_PPN = 3;

endpackage

// File: rtl/pgx_tlb_cam.sv
`timescale 1ns/1ps
module pgx_tlb_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_rd_ok,
  output logic              lk_wr_ok,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_rd_ok,
  input  logic              wr_wr_ok,
  input  logic              fl_en,
  input  logic              fl_all,
  input  logic [ASID_W-1:0] fl_asid
);

  logic              ent_v    [ENTRIES];
  logic [VPN_W-1:0]  ent_vpn  [ENTRIES];
  logic [ASID_W-1:0] ent_asid [ENTRIES];
  logic [PPN_W-1:0]  ent_ppn  [ENTRIES];
  logic              ent_rd   [ENTRIES];
  logic              ent_wr   [ENTRIES];
  logic [ENTRIES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign match[g] = ent_v[g] && (ent_vpn[g] == lk_vpn) && (ent_asid[g] == lk_asid);

      // the refill of this slot wins over a flush that lands in the same cycle
      always_ff @(posedge clk) begin
        if (rst) begin
          ent_v[g] <= 1'b0;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          ent_v[g] <= 1'b1;
        end else if (fl_en && (fl_all || (ent_asid[g] == fl_asid))) begin
          ent_v[g] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == IDX_W'(g))) begin
          ent_vpn[g]  <= wr_vpn;
          ent_asid[g] <= wr_asid;
          ent_ppn[g]  <= wr_ppn;
          ent_rd[g]   <= wr_rd_ok;
          ent_wr[g]   <= wr_wr_ok;
        end
      end
    end
  endgenerate

  // a page is only installed after a miss, so at most one slot matches
  always_comb begin
    lk_ppn   = '0;
    lk_rd_ok = 1'b0;
    lk_wr_ok = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_ppn   = lk_ppn | ent_ppn[i];
        lk_rd_ok = lk_rd_ok | ent_rd[i];
        lk_wr_ok = lk_wr_ok | ent_wr[i];
      end
    end
  end

  assign lk_hit = |match;

endmodule

// File: rtl/pgx_tlb_victim.sv
`timescale 1ns/1ps
module pgx_tlb_victim #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/pgx_tlb_walker.sv
`timescale 1ns/1ps
module pgx_tlb_walker
  import pgx_tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  parameter int MA_W   = 32,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int PTE_BITS = PPN_W + 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic                req_write,
  input  logic [ASID_W-1:0]   req_asid,
  input  logic                lk_hit,
  input  logic [PPN_W-1:0]    lk_ppn,
  input  logic                lk_rd_ok,
  input  logic                lk_wr_ok,
  input  logic [MA_W-1:0]     tbl_base,
  output logic                mem_req,
  output logic [MA_W-1:0]     mem_addr,
  input  logic                mem_gnt,
  input  logic                mem_rvalid,
  input  logic [PTE_BITS-1:0] mem_rdata,
  output logic                refill_en,
  output logic [VPN_W-1:0]    refill_vpn,
  output logic [ASID_W-1:0]   refill_asid,
  output logic [PPN_W-1:0]    refill_ppn,
  output logic                refill_rd,
  output logic                refill_wr,
  output logic                rsp_valid,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic                rsp_pfault,
  output logic                rsp_prot,
  output logic [VA_W-1:0]     fault_vaddr
);

  walk_st_t            st;
  logic [VA_W-1:0]     hold_vaddr;
  logic                hold_write;
  logic [ASID_W-1:0]   hold_asid;
  logic [PTE_BITS-1:0] pte_q;
  logic                hit_ok;
  logic                pte_ok;
  logic [VPN_W-1:0]    hold_vpn;

  assign hold_vpn  = hold_vaddr[VA_W-1:OFF_W];
  assign hit_ok    = req_write ? lk_wr_ok : lk_rd_ok;
  assign pte_ok    = hold_write ? pte_q[PTE_W] : pte_q[PTE_R];

  assign req_ready = (st == W_IDLE);
  assign mem_req   = (st == W_FETCH);
  assign mem_addr  = tbl_base + MA_W'(hold_vpn);

  assign refill_en   = (st == W_REFILL);
  assign refill_vpn  = hold_vpn;
  assign refill_asid = hold_asid;
  assign refill_ppn  = pte_q[PTE_PPN +: PPN_W];
  assign refill_rd   = pte_q[PTE_R];
  assign refill_wr   = pte_q[PTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= W_IDLE;
      hold_vaddr  <= '0;
      hold_write  <= 1'b0;
      hold_asid   <= '0;
      pte_q       <= '0;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_pfault  <= 1'b0;
      rsp_prot    <= 1'b0;
      fault_vaddr <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_pfault <= 1'b0;
      rsp_prot   <= 1'b0;
      case (st)
        W_IDLE: begin
          if (req_valid) begin
            hold_vaddr <= req_vaddr;
            hold_write <= req_write;
            hold_asid  <= req_asid;
            if (lk_hit) begin
              rsp_valid <= 1'b1;
              if (hit_ok) begin
                rsp_paddr <= {lk_ppn, req_vaddr[OFF_W-1:0]};
              end else begin
                rsp_paddr   <= '0;
                rsp_prot    <= 1'b1;
                fault_vaddr <= req_vaddr;
              end
            end else begin
              st <= W_FETCH;
            end
          end
        end
        W_FETCH: begin
          if (mem_gnt) st <= W_WAIT;
        end
        W_WAIT: begin
          if (mem_rvalid) begin
            pte_q <= mem_rdata;
            st    <= W_CHECK;
          end
        end
        W_CHECK: begin
          if (!pte_q[PTE_V]) begin
            rsp_valid   <= 1'b1;
            rsp_pfault  <= 1'b1;
            rsp_paddr   <= '0;
            fault_vaddr <= hold_vaddr;
            st          <= W_RESPOND;
          end else begin
            st <= W_REFILL;
          end
        end
        W_REFILL: begin
          rsp_valid <= 1'b1;
          if (pte_ok) begin
            rsp_paddr <= {pte_q[PTE_PPN +: PPN_W], hold_vaddr[OFF_W-1:0]};
          end else begin
            rsp_paddr   <= '0;
            rsp_prot    <= 1'b1;
            fault_vaddr <= hold_vaddr;
          end
          st <= W_RESPOND;
        end
        W_RESPOND: st <= W_IDLE;
        default:   st <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgx_tlb.sv
`timescale 1ns/1ps
module pgx_tlb #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 32,
  parameter int MA_W    = 32,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PPN_W    = PA_W - OFF_W,
  localparam int PTE_BITS = PPN_W + 3,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic                req_write,
  input  logic [ASID_W-1:0]   req_asid,
  output logic                rsp_valid,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic                rsp_pfault,
  output logic                rsp_prot_fault,
  output logic [VA_W-1:0]     fault_vaddr,
  input  logic [MA_W-1:0]     tbl_base,
  output logic                mem_req,
  input  logic                mem_gnt,
  output logic [MA_W-1:0]     mem_addr,
  input  logic                mem_rvalid,
  input  logic [PTE_BITS-1:0] mem_rdata,
  input  logic                flush_valid,
  input  logic                flush_all,
  input  logic [ASID_W-1:0]   flush_asid
);

  logic              lk_hit;
  logic [PPN_W-1:0]  lk_ppn;
  logic              lk_rd_ok;
  logic              lk_wr_ok;
  logic              refill_en;
  logic [VPN_W-1:0]  refill_vpn;
  logic [ASID_W-1:0] refill_asid;
  logic [PPN_W-1:0]  refill_ppn;
  logic              refill_rd;
  logic              refill_wr;
  logic [IDX_W-1:0]  vic_ptr;

  pgx_tlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) u_cam (
    .clk      (clk),
    .rst      (rst),
    .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
    .lk_asid  (req_asid),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .lk_rd_ok (lk_rd_ok),
    .lk_wr_ok (lk_wr_ok),
    .wr_en    (refill_en),
    .wr_idx   (vic_ptr),
    .wr_vpn   (refill_vpn),
    .wr_asid  (refill_asid),
    .wr_ppn   (refill_ppn),
    .wr_rd_ok (refill_rd),
    .wr_wr_ok (refill_wr),
    .fl_en    (flush_valid),
    .fl_all   (flush_all),
    .fl_asid  (flush_asid)
  );

  pgx_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk (clk),
    .rst (rst),
    .adv (refill_en),
    .ptr (vic_ptr)
  );

  pgx_tlb_walker #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .ASID_W(ASID_W), .MA_W(MA_W)
  ) u_walk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .req_write   (req_write),
    .req_asid    (req_asid),
    .lk_hit      (lk_hit),
    .lk_ppn      (lk_ppn),
    .lk_rd_ok    (lk_rd_ok),
    .lk_wr_ok    (lk_wr_ok),
    .tbl_base    (tbl_base),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .refill_en   (refill_en),
    .refill_vpn  (refill_vpn),
    .refill_asid (refill_asid),
    .refill_ppn  (refill_ppn),
    .refill_rd   (refill_rd),
    .refill_wr   (refill_wr),
    .rsp_valid   (rsp_valid),
    .rsp_paddr   (rsp_paddr),
    .rsp_pfault  (rsp_pfault),
    .rsp_prot    (rsp_prot_fault),
    .fault_vaddr (fault_vaddr)
  );

endmodule

// File: rtl/pgx_tlb_chk.sv
`timescale 1ns/1ps
module pgx_tlb_chk #(
  parameter int PA_W  = 32,
  parameter int MA_W  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_pfault,
  input logic             rsp_prot_fault,
  input logic             mem_req,
  input logic             mem_gnt,
  input logic [MA_W-1:0]  mem_addr,
  input logic             lk_hit,
  input logic             refill_en,
  input logic [IDX_W-1:0] vic_ptr
);

  // R2: an accepted hit completes in the following cycle
  p_hit_next_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && lk_hit) |=> rsp_valid);

  // R4: an accepted miss makes the block busy and gives no immediate response
  p_miss_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !lk_hit) |=> (!req_ready && !rsp_valid));

  // R4: the table read is held steady until it is granted
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R6: a faulting response carries no address
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_pfault || rsp_prot_fault)) |-> (rsp_paddr == '0));

  // R7: fault flags appear only with the done strobe
  p_flag_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_pfault || rsp_prot_fault) |-> rsp_valid);

  // R8: the victim pointer only moves on a refill, and a refill always moves it
  p_ptr_still_r8: assert property (@(posedge clk) disable iff (rst)
    !refill_en |=> $stable(vic_ptr));
  p_ptr_moves_r8: assert property (@(posedge clk) disable iff (rst)
    refill_en |=> (vic_ptr != $past(vic_ptr)));

  // R11: leaving reset the block is idle
  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !mem_req && req_ready));

endmodule

bind pgx_tlb pgx_tlb_chk #(.PA_W(PA_W), .MA_W(MA_W), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_paddr      (rsp_paddr),
  .rsp_pfault     (rsp_pfault),
  .rsp_prot_fault (rsp_prot_fault),
  .mem_req        (mem_req),
  .mem_gnt        (mem_gnt),
  .mem_addr       (mem_addr),
  .lk_hit         (lk_hit),
  .refill_en      (refill_en),
  .vic_ptr        (vic_ptr)
);

// File: tb/sim_pgx_tlb.sv
`timescale 1ns/1ps
module sim_pgx_tlb;

  localparam int VA_W = 16, OFF_W = 6, PA_W = 14, ASID_W = 2, ENTRIES = 32, MA_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int PTE_BITS = PPN_W + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic req_ready, rsp_valid, rsp_pfault, rsp_prot_fault, mem_req;
  logic [PA_W-1:0] rsp_paddr;
  logic [VA_W-1:0] fault_vaddr;
  logic [MA_W-1:0] tbl_base = 12'h100;
  logic [MA_W-1:0] mem_addr;
  logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [PTE_BITS-1:0] mem_rdata = '0;
  logic fl_task = 1'b0, fl_mem = 1'b0;
  logic flush_all = 1'b0;
  logic [ASID_W-1:0] flush_asid = '0;
  logic flush_valid;
  assign flush_valid = fl_task | fl_mem;

  always #2.5 clk = ~clk;

  pgx_tlb #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .ASID_W(ASID_W),
            .ENTRIES(ENTRIES), .MA_W(MA_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_asid(req_asid),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_pfault(rsp_pfault),
    .rsp_prot_fault(rsp_prot_fault), .fault_vaddr(fault_vaddr), .tbl_base(tbl_base),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .flush_valid(flush_valid), .flush_all(flush_all),
    .flush_asid(flush_asid));

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string ctx, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, ctx, act, exp);
    end
  endtask

  // table entry content as a function of its address (R5 layout)
  function automatic logic [PTE_BITS-1:0] pte_of(input logic [MA_W-1:0] a);
    logic v, r, w;
    logic [PPN_W-1:0] ppn;
    v = (a % 7) != 3;
    r = (a % 5) != 1;
    w = (a % 3) == 0;
    ppn = PPN_W'(a * 29 + 5);
    return {ppn, w, r, v};
  endfunction

  // memory model: variable grant delay and read latency
  int n_grant = 0, gdel = 0, lat_c = 0, rv_cyc = 0, fl_cnt = 0;
  bit pend = 1'b0, fl_arm = 1'b0;
  logic [MA_W-1:0] last_addr = '0;
  always @(negedge clk) begin
    mem_gnt    <= 1'b0;
    mem_rvalid <= 1'b0;
    fl_mem     <= 1'b0;
    if (fl_cnt != 0) begin
      if (fl_cnt == 1) fl_mem <= 1'b1;
      fl_cnt <= fl_cnt - 1;
    end
    if (pend) begin
      if (lat_c == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pte_of(last_addr);
        pend       <= 1'b0;
        rv_cyc     <= cyc;
        if (fl_arm) fl_cnt <= 2;
      end else begin
        lat_c <= lat_c - 1;
      end
    end else if (mem_req && !mem_gnt) begin
      if (gdel == 0) begin
        mem_gnt   <= 1'b1;
        pend      <= 1'b1;
        last_addr <= mem_addr;
        lat_c     <= n_grant % 3;
        gdel      <= (n_grant + 1) % 2;
        n_grant   <= n_grant + 1;
      end else begin
        gdel <= gdel - 1;
      end
    end
  end

  // reference model of the slots
  bit              mv    [ENTRIES];
  logic [VPN_W-1:0]  mvpn  [ENTRIES];
  logic [ASID_W-1:0] masid [ENTRIES];
  logic [PPN_W-1:0]  mppn  [ENTRIES];
  bit              mr    [ENTRIES];
  bit              mw    [ENTRIES];
  int              mptr = 0;

  task automatic m_flush(input bit all, input logic [ASID_W-1:0] a);
    for (int i = 0; i < ENTRIES; i++)
      if (all || masid[i] == a) mv[i] = 1'b0;
  endtask

  task automatic do_flush(input bit all, input logic [ASID_W-1:0] a);
    @(negedge clk);
    fl_task = 1'b1; flush_all = all; flush_asid = a;
    @(negedge clk);
    fl_task = 1'b0;
    m_flush(all, a);
  endtask

  task automatic access(input logic [VA_W-1:0] va, input bit wr, input logic [ASID_W-1:0] asid,
                        input bit with_fl, input bit fall, input logic [ASID_W-1:0] fasid,
                        input string htag);
    int hidx, lat, g0, scyc;
    logic [VPN_W-1:0] vpn;
    logic [MA_W-1:0] ea;
    logic [PTE_BITS-1:0] pte;
    logic [PA_W-1:0] exp_pa;
    bit ok, e_pf, e_pr, rdy_at;
    string ctx;
    vpn = va[VA_W-1:OFF_W];
    ctx = $sformatf("va=%0h wr=%0d asid=%0d", va, wr, asid);
    hidx = -1;
    for (int i = 0; i < ENTRIES; i++)
      if (mv[i] && mvpn[i] == vpn && masid[i] == asid) hidx = i;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    g0 = n_grant;
    req_vaddr = va; req_write = wr; req_asid = asid; req_valid = 1'b1;
    if (with_fl) begin fl_task = 1'b1; flush_all = fall; flush_asid = fasid; end
    @(negedge clk);
    req_valid = 1'b0; fl_task = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
    scyc = cyc;
    rdy_at = req_ready;
    if (with_fl) m_flush(fall, fasid);
    e_pf = 1'b0; e_pr = 1'b0; exp_pa = '0;
    if (hidx >= 0) begin
      chk(lat == 1 && n_grant == g0, htag, {ctx, " hit"}, lat, 1);
      chk(rdy_at == 1'b1, "R2", {ctx, " ready at strobe"}, rdy_at, 1);
      ok = wr ? mw[hidx] : mr[hidx];
      if (ok) exp_pa = {mppn[hidx], va[OFF_W-1:0]}; else e_pr = 1'b1;
    end else begin
      ea = tbl_base + MA_W'(vpn);
      pte = pte_of(ea);
      chk(lat > 1 && n_grant == g0 + 1 && last_addr == ea, htag == "R4" ? "R4" : {htag, "/R4"},
          {ctx, " walk addr"}, last_addr, ea);
      if (!pte[0]) begin
        e_pf = 1'b1;
        chk(scyc - rv_cyc == 2, "R6", {ctx, " fault timing"}, scyc - rv_cyc, 2);
      end else begin
        chk(scyc - rv_cyc == 3, "R5", {ctx, " refill timing"}, scyc - rv_cyc, 3);
        if (fl_arm) m_flush(flush_all, flush_asid);
        mv[mptr] = 1'b1; mvpn[mptr] = vpn; masid[mptr] = asid;
        mppn[mptr] = pte[3 +: PPN_W]; mr[mptr] = pte[1]; mw[mptr] = pte[2];
        mptr = (mptr + 1) % ENTRIES;
        ok = wr ? pte[2] : pte[1];
        if (ok) exp_pa = {pte[3 +: PPN_W], va[OFF_W-1:0]}; else e_pr = 1'b1;
      end
    end
    chk(rsp_paddr == exp_pa, "R1", {ctx, " paddr"}, rsp_paddr, exp_pa);
    chk(rsp_pfault == e_pf, "R6", {ctx, " page fault"}, rsp_pfault, e_pf);
    chk(rsp_prot_fault == e_pr, "R7", {ctx, " prot fault"}, rsp_prot_fault, e_pr);
    if (e_pf || e_pr) chk(fault_vaddr == va, "R6", {ctx, " fault vaddr"}, fault_vaddr, va);
  endtask

  function automatic logic [VA_W-1:0] mk_va(input int p, input int off);
    return {VPN_W'(p), OFF_W'(off)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      mv[i] = 1'b0; mvpn[i] = '0; masid[i] = '0; mppn[i] = '0; mr[i] = 1'b0; mw[i] = 1'b0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "strobe after reset", rsp_valid, 0);
    chk(mem_req == 1'b0, "R11", "mem_req after reset", mem_req, 0);
    chk(fault_vaddr == '0, "R11", "fault_vaddr after reset", fault_vaddr, 0);

    // fill past capacity, then revisit: round-robin replacement (R8)
    for (int p = 0; p < 40; p++) access(mk_va(p, p * 3), p[1], 2'd0, 0, 0, 0, "R8");
    for (int p = 0; p < 40; p++) access(mk_va(p, 63 - p), 1'b0, 2'd0, 0, 0, 0, "R8");
    // identifier tag separates identical pages (R3), writes checked for permission (R7)
    for (int p = 30; p < 38; p++) access(mk_va(p, 5), 1'b0, 2'd1, 0, 0, 0, "R3");
    for (int p = 30; p < 38; p++) access(mk_va(p, 9), 1'b1, 2'd0, 0, 0, 0, "R7");
    for (int p = 30; p < 38; p++) access(mk_va(p, 9), 1'b1, 2'd1, 0, 0, 0, "R7");
    // flush by identifier only, then flush everything (R9)
    do_flush(1'b0, 2'd1);
    for (int p = 30; p < 34; p++) access(mk_va(p, 1), 1'b0, 2'd1, 0, 0, 0, "R9");
    for (int p = 34; p < 38; p++) access(mk_va(p, 2), 1'b0, 2'd0, 0, 0, 0, "R9");
    do_flush(1'b1, 2'd0);
    for (int p = 34; p < 38; p++) access(mk_va(p, 2), 1'b0, 2'd0, 0, 0, 0, "R9");
    // R10: lookup in the same cycle as a full flush sees the old contents
    access(mk_va(36, 7), 1'b0, 2'd0, 0, 0, 0, "R10");
    access(mk_va(36, 7), 1'b0, 2'd0, 1, 1, 2'd0, "R10");
    access(mk_va(36, 7), 1'b0, 2'd0, 0, 0, 0, "R10");
    // R10: a full flush in the refill cycle keeps the fresh entry only
    access(mk_va(35, 4), 1'b0, 2'd0, 0, 0, 0, "R10");
    fl_arm = 1'b1; flush_all = 1'b1;
    access(mk_va(12, 4), 1'b0, 2'd2, 0, 0, 0, "R10");
    fl_arm = 1'b0;
    access(mk_va(12, 8), 1'b0, 2'd2, 0, 0, 0, "R10");
    access(mk_va(35, 4), 1'b0, 2'd0, 0, 0, 0, "R10");
    // new table base changes the walk address (R4)
    tbl_base = 12'h300;
    for (int p = 0; p < 6; p++) access(mk_va(p, 11), p[0], 2'd3, 0, 0, 0, "R4");
    for (int p = 0; p < 6; p++) access(mk_va(p, 12), 1'b0, 2'd3, 0, 0, 0, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule